// File: doc/BRIEF.md
# PTP Event Packet Rule Matcher

This block decides, one frame at a time, whether a frame is a precision time protocol event packet. The header fields have already been parsed out of the byte stream by an upstream stage and are presented together with a one-cycle valid: the destination MAC address, the Ethertype, IPv4/IPv6 flags, the IP destination address, the UDP destination port, the PTP version field, and the traffic direction (receive or transmit).

Eleven fixed or configurable field comparators feed fourteen rules. Each rule is the AND of two comparators. Any comparator and any rule can be masked off. A per-direction enable and two per-direction version bits gate the result.

One cycle after a frame is presented, the block raises a single-cycle detect strobe. It reports the index of the lowest-numbered rule that matched. A configuration load strobe writes the masks, the enables, the user Ethertype and the user MAC address, all in one cycle.

Top module: `ptp_rule_matcher`

## Requirements
- R1: After reset, every comparator and every rule is masked and all enables are clear, so no frame is detected until configuration is loaded.
- R2: Comparator bit positions in the 11-bit comparator mask are as follows. A 1 in a mask bit disables that comparator.
  - bit0: IPv4 destination 224.0.1.129
  - bit1: IPv4 destination 224.0.0.107
  - bit2: IPv6 destination FF0x::181
  - bit3: IPv6 destination FF02::6B
  - bit4: UDP port 319
  - bit5: UDP port 320
  - bit6: Ethertype 0x88F7
  - bit7: user Ethertype
  - bit8: MAC 01-1B-19-00-00-00
  - bit9: MAC 01-80-C2-00-00-0E
  - bit10: user MAC
- R3: The rules are numbered and paired as follows.
  - Rules 0 to 3: IPv4 address A/A/B/B with UDP port 319/320/319/320.
  - Rules 4 to 7: the same pattern for IPv6.
  - Rules 8 to 13: (MAC 01-1B-19, 0x88F7), (MAC 01-80-C2, 0x88F7), (MAC 01-1B-19, user Ethertype), (MAC 01-80-C2, user Ethertype), (user MAC, 0x88F7), (user MAC, user Ethertype).
- R4: A 1 in bit r of the 14-bit rule mask disables rule r.
- R5: Rules 0 to 3 match only frames flagged IPv4, and rules 4 to 7 match only frames flagged IPv6.
- R6: In the 6-bit enable, bits [2:0] are receive (enable, V1, V2) and bits [5:3] are transmit (enable, V1, V2). No frame is detected in a direction whose enable bit is clear.
- R7: A PTP version of 1 is accepted only if that direction's V1 bit is set, and version 2 only if its V2 bit is set. Every other version is never detected.
- R8: When several unmasked rules match, the lowest rule index is reported.
- R9: The detect strobe is high for exactly the one cycle after a detected frame's valid cycle, and never follows a cycle without a frame valid.
- R10: A configuration load replaces all configuration at once and applies to frames presented from the next cycle on.
- R11: The FF0x::181 comparator ignores the scope nibble (address bits [115:112]) but requires the rest of the address to be exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load all configuration fields below |
| cfg_param_mask | input | 11 | Comparator mask, 1 disables |
| cfg_rule_mask | input | 14 | Rule mask, 1 disables |
| cfg_enable | input | 6 | Direction and version enables |
| cfg_user_ethertype | input | 16 | Configurable Ethertype value |
| cfg_user_mac_da | input | 48 | Configurable destination MAC value |
| frm_valid | input | 1 | Header fields are valid this cycle |
| frm_dir | input | 1 | 0 receive, 1 transmit |
| frm_mac_da | input | 48 | Destination MAC address |
| frm_ethertype | input | 16 | Ethertype |
| frm_is_ipv4 | input | 1 | Frame carries IPv4 |
| frm_is_ipv6 | input | 1 | Frame carries IPv6 |
| frm_ip_da | input | 128 | IP destination; IPv4 uses bits [31:0] |
| frm_udp_dport | input | 16 | UDP destination port |
| frm_ptp_version | input | 4 | PTP version field |
| det_strobe | output | 1 | Frame detected as PTP event packet |
| det_rule | output | 4 | Index of reported rule, 0 when no strobe |

## Verification
A stuck or wrong mask or enable register shows up as a missing or spurious strobe on the first frame after the faulty load, exactly one cycle after that frame's valid. A wrong rule pairing or priority order shows up only as a wrong det_rule value. The bench therefore drives frames that hit exactly one rule, as well as frames that hit several at once. Because the block keeps no per-frame state, any fault is visible on the very next frame that exercises the affected comparator or rule.

// File: rtl/ptp_match_pkg.sv
package ptp_match_pkg;

    localparam int NUM_PARAMS = 11;
    localparam int NUM_RULES  = 14;
    localparam int RULE_IDX_W = $clog2(NUM_RULES);
    localparam int ENABLE_W   = 6;
    localparam int MAC_W      = 48;
    localparam int ETYPE_W    = 16;
    localparam int IP_W       = 128;
    localparam int PORT_W     = 16;
    localparam int VER_W      = 4;

    // comparator indices
    localparam int P_IP4_A  = 0;
    localparam int P_IP4_B  = 1;
    localparam int P_IP6_A  = 2;
    localparam int P_IP6_B  = 3;
    localparam int P_UDP_A  = 4;
    localparam int P_UDP_B  = 5;
    localparam int P_ET_STD = 6;
    localparam int P_ET_USR = 7;
    localparam int P_MAC_A  = 8;
    localparam int P_MAC_B  = 9;
    localparam int P_MAC_U  = 10;

    localparam logic [31:0]     IP4_A_VAL  = 32'hE000_0181;
    localparam logic [31:0]     IP4_B_VAL  = 32'hE000_006B;
    localparam logic [IP_W-1:0] IP6_B_VAL  = 128'hFF02_0000_0000_0000_0000_0000_0000_006B;
    localparam logic [111:0]    IP6_A_TAIL = 112'h181;
    localparam logic [PORT_W-1:0] UDP_A_VAL = 16'd319;
    localparam logic [PORT_W-1:0] UDP_B_VAL = 16'd320;
    localparam logic [ETYPE_W-1:0] ET_STD_VAL = 16'h88F7;
    localparam logic [MAC_W-1:0] MAC_A_VAL = 48'h01_1B_19_00_00_00;
    localparam logic [MAC_W-1:0] MAC_B_VAL = 48'h01_80_C2_00_00_0E;

    localparam logic [VER_W-1:0] VER_ONE = 4'd1;
    localparam logic [VER_W-1:0] VER_TWO = 4'd2;

    typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} ptp_dir_e;
    typedef enum logic [1:0] {IPQ_NONE, IPQ_V4, IPQ_V6} ip_qual_e;

    typedef struct packed {
        ptp_dir_e             dir;
        logic [MAC_W-1:0]     mac_da;
        logic [ETYPE_W-1:0]   ethertype;
        logic                 is_ipv4;
        logic                 is_ipv6;
        logic [IP_W-1:0]      ip_da;
        logic [PORT_W-1:0]    udp_dport;
        logic [VER_W-1:0]     ptp_version;
    } frame_hdr_t;

    typedef struct packed {
        logic [NUM_PARAMS-1:0] param_mask;
        logic [NUM_RULES-1:0]  rule_mask;
        logic [ENABLE_W-1:0]   enable;
        logic [ETYPE_W-1:0]    user_ethertype;
        logic [MAC_W-1:0]      user_mac_da;
    } match_cfg_t;

    // first comparator of a rule: an address (IP or MAC)
    function automatic int rule_first(input int r);
        if (r < 4)       return P_IP4_A + (r >> 1);
        else if (r < 8)  return P_IP6_A + ((r - 4) >> 1);
        else if (r < 12) return P_MAC_A + (r & 1);
        else             return P_MAC_U;
    endfunction

    // second comparator of a rule: a UDP port or an Ethertype
    function automatic int rule_second(input int r);
        if (r < 8)       return P_UDP_A + (r & 1);
        else if (r < 12) return P_ET_STD + ((r - 8) >> 1);
        else             return P_ET_STD + (r - 12);
    endfunction

    function automatic ip_qual_e rule_qual(input int r);
        if (r < 4)      return IPQ_V4;
        else if (r < 8) return IPQ_V6;
        else            return IPQ_NONE;
    endfunction

    function automatic logic version_ok(input logic [ENABLE_W-1:0] en,
                                        input ptp_dir_e dir,
                                        input logic [VER_W-1:0] ver);
        logic [2:0] grp;
        grp = (dir == DIR_TX) ? en[5:3] : en[2:0];
        return grp[0] && ((ver == VER_ONE && grp[1]) || (ver == VER_TWO && grp[2]));
    endfunction

endpackage

// File: rtl/ptp_cfg_regs.sv
module ptp_cfg_regs
    import ptp_match_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  match_cfg_t cfg_in,
    output match_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.param_mask     <= '1;
            cfg_q.rule_mask      <= '1;
            cfg_q.enable         <= '0;
            cfg_q.user_ethertype <= '0;
            cfg_q.user_mac_da    <= '0;
        end else if (wr) begin
            cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/ptp_param_cmp.sv
module ptp_param_cmp
    import ptp_match_pkg::*;
(
    input  frame_hdr_t             hdr,
    input  match_cfg_t             cfg,
    output logic [NUM_PARAMS-1:0]  param_hit
);
    logic [NUM_PARAMS-1:0] raw;

    always_comb begin
        raw = '0;
        raw[P_IP4_A]  = hdr.is_ipv4 && (hdr.ip_da[31:0] == IP4_A_VAL);
        raw[P_IP4_B]  = hdr.is_ipv4 && (hdr.ip_da[31:0] == IP4_B_VAL);
        raw[P_IP6_A]  = hdr.is_ipv6 && (hdr.ip_da[127:120] == 8'hFF)
                        && (hdr.ip_da[119:116] == 4'h0)
                        && (hdr.ip_da[111:0] == IP6_A_TAIL);
        raw[P_IP6_B]  = hdr.is_ipv6 && (hdr.ip_da == IP6_B_VAL);
        raw[P_UDP_A]  = (hdr.udp_dport == UDP_A_VAL);
        raw[P_UDP_B]  = (hdr.udp_dport == UDP_B_VAL);
        raw[P_ET_STD] = (hdr.ethertype == ET_STD_VAL);
        raw[P_ET_USR] = (hdr.ethertype == cfg.user_ethertype);
        raw[P_MAC_A]  = (hdr.mac_da == MAC_A_VAL);
        raw[P_MAC_B]  = (hdr.mac_da == MAC_B_VAL);
        raw[P_MAC_U]  = (hdr.mac_da == cfg.user_mac_da);
    end

    assign param_hit = raw & ~cfg.param_mask;
endmodule

// File: rtl/ptp_rule_eval.sv
module ptp_rule_eval
    import ptp_match_pkg::*;
(
    input  logic [NUM_PARAMS-1:0] param_hit,
    input  logic [NUM_RULES-1:0]  rule_mask,
    input  logic                  is_ipv4,
    input  logic                  is_ipv6,
    output logic [NUM_RULES-1:0]  rule_hit
);
    for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
        localparam int       PA = rule_first(r);
        localparam int       PB = rule_second(r);
        localparam ip_qual_e QL = rule_qual(r);
        logic qual_ok;
        if (QL == IPQ_V4) begin : g_v4
            assign qual_ok = is_ipv4;
        end else if (QL == IPQ_V6) begin : g_v6
            assign qual_ok = is_ipv6;
        end else begin : g_l2
            assign qual_ok = 1'b1;
        end
        assign rule_hit[r] = param_hit[PA] && param_hit[PB] && qual_ok && !rule_mask[r];
    end
endmodule

// File: rtl/ptp_prio_pick.sv
module ptp_prio_pick
    import ptp_match_pkg::*;
(
    input  logic [NUM_RULES-1:0]  rule_hit,
    output logic                  any_hit,
    output logic [RULE_IDX_W-1:0] first_idx
);
    always_comb begin
        any_hit   = 1'b0;
        first_idx = '0;
        for (int i = NUM_RULES - 1; i >= 0; i--) begin
            if (rule_hit[i]) begin
                any_hit   = 1'b1;
                first_idx = RULE_IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ptp_rule_matcher.sv
module ptp_rule_matcher
    import ptp_match_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_wr,
    input  logic [NUM_PARAMS-1:0]  cfg_param_mask,
    input  logic [NUM_RULES-1:0]   cfg_rule_mask,
    input  logic [ENABLE_W-1:0]    cfg_enable,
    input  logic [ETYPE_W-1:0]     cfg_user_ethertype,
    input  logic [MAC_W-1:0]       cfg_user_mac_da,
    input  logic                   frm_valid,
    input  logic                   frm_dir,
    input  logic [MAC_W-1:0]       frm_mac_da,
    input  logic [ETYPE_W-1:0]     frm_ethertype,
    input  logic                   frm_is_ipv4,
    input  logic                   frm_is_ipv6,
    input  logic [IP_W-1:0]        frm_ip_da,
    input  logic [PORT_W-1:0]      frm_udp_dport,
    input  logic [VER_W-1:0]       frm_ptp_version,
    output logic                   det_strobe,
    output logic [RULE_IDX_W-1:0]  det_rule
);
    match_cfg_t            cfg_in;
    match_cfg_t            cfg_q;
    frame_hdr_t            hdr;
    logic [NUM_PARAMS-1:0] param_hit;
    logic [NUM_RULES-1:0]  rule_hit;
    logic                  any_hit;
    logic [RULE_IDX_W-1:0] first_idx;
    logic                  accept;

    assign cfg_in.param_mask     = cfg_param_mask;
    assign cfg_in.rule_mask      = cfg_rule_mask;
    assign cfg_in.enable         = cfg_enable;
    assign cfg_in.user_ethertype = cfg_user_ethertype;
    assign cfg_in.user_mac_da    = cfg_user_mac_da;

    assign hdr.dir         = ptp_dir_e'(frm_dir);
    assign hdr.mac_da      = frm_mac_da;
    assign hdr.ethertype   = frm_ethertype;
    assign hdr.is_ipv4     = frm_is_ipv4;
    assign hdr.is_ipv6     = frm_is_ipv6;
    assign hdr.ip_da       = frm_ip_da;
    assign hdr.udp_dport   = frm_udp_dport;
    assign hdr.ptp_version = frm_ptp_version;

    ptp_cfg_regs u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr     (cfg_wr),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    ptp_param_cmp u_cmp (
        .hdr       (hdr),
        .cfg       (cfg_q),
        .param_hit (param_hit)
    );

    ptp_rule_eval u_rules (
        .param_hit (param_hit),
        .rule_mask (cfg_q.rule_mask),
        .is_ipv4   (hdr.is_ipv4),
        .is_ipv6   (hdr.is_ipv6),
        .rule_hit  (rule_hit)
    );

    ptp_prio_pick u_pick (
        .rule_hit  (rule_hit),
        .any_hit   (any_hit),
        .first_idx (first_idx)
    );

    assign accept = frm_valid && any_hit
                    && version_ok(cfg_q.enable, hdr.dir, hdr.ptp_version);

    always_ff @(posedge clk) begin
        if (rst) begin
            det_strobe <= 1'b0;
            det_rule   <= '0;
        end else begin
            det_strobe <= accept;
            det_rule   <= accept ? first_idx : '0;
        end
    end
endmodule

// File: rtl/ptp_rule_matcher_chk.sv
module ptp_rule_matcher_chk
    import ptp_match_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  frm_valid,
    input logic                  frm_dir,
    input logic                  frm_is_ipv4,
    input logic                  frm_is_ipv6,
    input logic [VER_W-1:0]      frm_ptp_version,
    input logic [NUM_RULES-1:0]  rule_mask_q,
    input logic [ENABLE_W-1:0]   enable_q,
    input logic                  det_strobe,
    input logic [RULE_IDX_W-1:0] det_rule
);
    logic dir_on;
    assign dir_on = frm_dir ? enable_q[3] : enable_q[0];

    AST_NO_STROBE_WITHOUT_FRAME: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> !det_strobe); // R9

    AST_RULE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        det_strobe |-> (int'(det_rule) < NUM_RULES)); // R3

    AST_ALL_RULES_MASKED: assert property (@(posedge clk) disable iff (rst)
        (rule_mask_q == '1) |=> !det_strobe); // R4

    AST_DIR_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !dir_on) |=> !det_strobe); // R6

    AST_BAD_VERSION: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_ptp_version != VER_ONE && frm_ptp_version != VER_TWO)
        |=> !det_strobe); // R7

    AST_IPV4_QUAL: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !frm_is_ipv4) |=> !(det_strobe && det_rule < 4'd4)); // R5

    AST_IPV6_QUAL: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !frm_is_ipv6)
        |=> !(det_strobe && det_rule >= 4'd4 && det_rule < 4'd8)); // R5

    AST_IDLE_RULE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !det_strobe |-> (det_rule == '0)); // R9
endmodule

bind ptp_rule_matcher ptp_rule_matcher_chk chk_i (
    .clk             (clk),
    .rst             (rst),
    .frm_valid       (frm_valid),
    .frm_dir         (frm_dir),
    .frm_is_ipv4     (frm_is_ipv4),
    .frm_is_ipv6     (frm_is_ipv6),
    .frm_ptp_version (frm_ptp_version),
    .rule_mask_q     (cfg_q.rule_mask),
    .enable_q        (cfg_q.enable),
    .det_strobe      (det_strobe),
    .det_rule        (det_rule)
);

// File: tb/ptp_rule_matcher_tb_top.sv
module ptp_rule_matcher_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_wr = 1'b0;
    logic [10:0]  cfg_param_mask = '0;
    logic [13:0]  cfg_rule_mask = '0;
    logic [5:0]   cfg_enable = '0;
    logic [15:0]  cfg_user_ethertype = '0;
    logic [47:0]  cfg_user_mac_da = '0;
    logic         frm_valid = 1'b0;
    logic         frm_dir = 1'b0;
    logic [47:0]  frm_mac_da = '0;
    logic [15:0]  frm_ethertype = '0;
    logic         frm_is_ipv4 = 1'b0;
    logic         frm_is_ipv6 = 1'b0;
    logic [127:0] frm_ip_da = '0;
    logic [15:0]  frm_udp_dport = '0;
    logic [3:0]   frm_ptp_version = '0;
    logic         det_strobe;
    logic [3:0]   det_rule;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    localparam logic [47:0]  MAC0  = 48'h01_1B_19_00_00_00;
    localparam logic [47:0]  MAC1  = 48'h01_80_C2_00_00_0E;
    localparam logic [47:0]  UMAC  = 48'h02_AA_BB_CC_DD_EE;
    localparam logic [47:0]  PLAIN = 48'h00_11_22_33_44_55;
    localparam logic [15:0]  UET   = 16'h1234;
    localparam logic [127:0] V4A   = {96'h0, 32'hE000_0181};
    localparam logic [127:0] V4B   = {96'h0, 32'hE000_006B};
    localparam logic [127:0] V6A5  = 128'hFF05_0000_0000_0000_0000_0000_0000_0181;
    localparam logic [127:0] V6A15 = 128'hFF15_0000_0000_0000_0000_0000_0000_0181;
    localparam logic [127:0] V6B   = 128'hFF02_0000_0000_0000_0000_0000_0000_006B;

    always #10 clk = ~clk;

    ptp_rule_matcher dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr),
        .cfg_param_mask(cfg_param_mask), .cfg_rule_mask(cfg_rule_mask),
        .cfg_enable(cfg_enable), .cfg_user_ethertype(cfg_user_ethertype),
        .cfg_user_mac_da(cfg_user_mac_da),
        .frm_valid(frm_valid), .frm_dir(frm_dir), .frm_mac_da(frm_mac_da),
        .frm_ethertype(frm_ethertype), .frm_is_ipv4(frm_is_ipv4),
        .frm_is_ipv6(frm_is_ipv6), .frm_ip_da(frm_ip_da),
        .frm_udp_dport(frm_udp_dport), .frm_ptp_version(frm_ptp_version),
        .det_strobe(det_strobe), .det_rule(det_rule)
    );

    task automatic check(input string req, input logic act_s, input logic [3:0] act_r,
                         input logic exp_s, input logic [3:0] exp_r);
        checks++;
        if (act_s !== exp_s || act_r !== exp_r) begin
            errors++;
            $display("FAIL %s: strobe=%0b rule=%0d expected strobe=%0b rule=%0d",
                     req, act_s, act_r, exp_s, exp_r);
        end
    endtask

    task automatic load_cfg(input logic [10:0] pm, input logic [13:0] rm, input logic [5:0] en);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_param_mask = pm; cfg_rule_mask = rm; cfg_enable = en;
        cfg_user_ethertype = UET; cfg_user_mac_da = UMAC;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // present one frame, sample the strobe after the registering edge
    task automatic frame(input string req, input logic dir, input logic [47:0] mac,
                         input logic [15:0] et, input logic v4, input logic v6,
                         input logic [127:0] ip, input logic [15:0] port,
                         input logic [3:0] ver, input logic exp_s, input logic [3:0] exp_r);
        @(negedge clk);
        frm_valid = 1'b1; frm_dir = dir; frm_mac_da = mac; frm_ethertype = et;
        frm_is_ipv4 = v4; frm_is_ipv6 = v6; frm_ip_da = ip; frm_udp_dport = port;
        frm_ptp_version = ver;
        @(negedge clk);
        frm_valid = 1'b0;
        check(req, det_strobe, det_rule, exp_s, exp_r);
    endtask

    task automatic l2(input string req, input logic [47:0] mac, input logic [15:0] et,
                      input logic exp_s, input logic [3:0] exp_r);
        frame(req, 1'b0, mac, et, 1'b0, 1'b0, '0, 16'd1000, 4'd2, exp_s, exp_r);
    endtask

    task automatic ip(input string req, input logic v4, input logic v6,
                      input logic [127:0] addr, input logic [15:0] port,
                      input logic exp_s, input logic [3:0] exp_r);
        frame(req, 1'b0, PLAIN, 16'h0800, v4, v6, addr, port, 4'd2, exp_s, exp_r);
    endtask

    task automatic t_reset();
        check("R1 idle after reset", det_strobe, det_rule, 1'b0, 4'd0);
        l2("R1 all masked after reset", MAC0, 16'h88F7, 1'b0, 4'd0);
        ip("R1 ip masked after reset", 1'b1, 1'b0, V4A, 16'd319, 1'b0, 4'd0);
    endtask

    task automatic t_l2_rules();
        load_cfg('0, '0, 6'b111111);   // R10 load takes effect next frame
        l2("R3 rule8", MAC0, 16'h88F7, 1'b1, 4'd8);
        l2("R3 rule9", MAC1, 16'h88F7, 1'b1, 4'd9);
        l2("R3 rule10", MAC0, UET, 1'b1, 4'd10);
        l2("R3 rule11", MAC1, UET, 1'b1, 4'd11);
        l2("R3 rule12", UMAC, 16'h88F7, 1'b1, 4'd12);
        l2("R3 rule13", UMAC, UET, 1'b1, 4'd13);
        l2("R3 no match plain", PLAIN, 16'h88F7, 1'b0, 4'd0);
    endtask

    task automatic t_ip_rules();
        ip("R3 rule0", 1'b1, 1'b0, V4A, 16'd319, 1'b1, 4'd0);
        ip("R3 rule1", 1'b1, 1'b0, V4A, 16'd320, 1'b1, 4'd1);
        ip("R3 rule2", 1'b1, 1'b0, V4B, 16'd319, 1'b1, 4'd2);
        ip("R3 rule3", 1'b1, 1'b0, V4B, 16'd320, 1'b1, 4'd3);
        ip("R11 rule4 scope 5", 1'b0, 1'b1, V6A5, 16'd319, 1'b1, 4'd4);
        ip("R11 bad nibble", 1'b0, 1'b1, V6A15, 16'd319, 1'b0, 4'd0);
        ip("R3 rule7", 1'b0, 1'b1, V6B, 16'd320, 1'b1, 4'd7);
        ip("R5 v4 addr not flagged", 1'b0, 1'b0, V4A, 16'd319, 1'b0, 4'd0);
        ip("R5 v6 addr not flagged", 1'b1, 1'b0, V6B, 16'd319, 1'b0, 4'd0);
    endtask

    task automatic t_priority_and_masks();
        frame("R8 rule1 beats rule8", 1'b0, MAC0, 16'h88F7, 1'b1, 1'b0, V4A, 16'd320,
              4'd2, 1'b1, 4'd1);
        load_cfg('0, 14'h0002, 6'b111111);
        frame("R4 rule1 masked gives 8", 1'b0, MAC0, 16'h88F7, 1'b1, 1'b0, V4A, 16'd320,
              4'd2, 1'b1, 4'd8);
        load_cfg(11'h040, '0, 6'b111111);
        l2("R2 mask 88F7 cmp", MAC0, 16'h88F7, 1'b0, 4'd0);
        l2("R2 user et still on", MAC0, UET, 1'b1, 4'd10);
        load_cfg(11'h010, '0, 6'b111111);
        ip("R2 mask port319", 1'b1, 1'b0, V4A, 16'd319, 1'b0, 4'd0);
        ip("R2 port320 still on", 1'b1, 1'b0, V4A, 16'd320, 1'b1, 4'd1);
    endtask

    task automatic t_version_dir();
        load_cfg('0, '0, 6'b000101);   // RX enable + V2 only
        frame("R7 v1 rejected", 1'b0, MAC0, 16'h88F7, 1'b0, 1'b0, '0, 16'd0, 4'd1, 1'b0, 4'd0);
        frame("R7 v2 accepted", 1'b0, MAC0, 16'h88F7, 1'b0, 1'b0, '0, 16'd0, 4'd2, 1'b1, 4'd8);
        load_cfg('0, '0, 6'b111111);
        frame("R7 v3 never", 1'b0, MAC0, 16'h88F7, 1'b0, 1'b0, '0, 16'd0, 4'd3, 1'b0, 4'd0);
        load_cfg('0, '0, 6'b011000);   // TX enable + V1 only
        frame("R6 rx off", 1'b0, MAC0, 16'h88F7, 1'b0, 1'b0, '0, 16'd0, 4'd1, 1'b0, 4'd0);
        frame("R6 tx on", 1'b1, MAC1, 16'h88F7, 1'b0, 1'b0, '0, 16'd0, 4'd1, 1'b1, 4'd9);
        load_cfg('0, '0, 6'b001001);   // enables without version bits
        frame("R6 no version bits", 1'b1, MAC1, 16'h88F7, 1'b0, 1'b0, '0, 16'd0, 4'd1, 1'b0, 4'd0);
    endtask

    task automatic t_strobe_width();
        load_cfg('0, '0, 6'b111111);
        l2("R9 strobe on hit", UMAC, UET, 1'b1, 4'd13);
        @(negedge clk);
        check("R9 strobe one cycle", det_strobe, det_rule, 1'b0, 4'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_l2_rules();
        t_ip_rules();
        t_priority_and_masks();
        t_version_dir();
        t_strobe_width();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule